// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a register of eight stages (the width is a parameter) that does one of four things on each rising clock edge. It can keep its contents, shift toward the high end, shift toward the low end, or capture a parallel word. A two-bit mode input picks the operation. Stage 0 is the low end and stage `WIDTH-1` is the high end. Each end has its own serial input.

Parallel input and parallel output share one set of pins. In this block the pins are split into three ports: an input word, an output word and a drive-enable. The pins are driven only when both active-high disable inputs are low and the block is not in load mode. Load mode always releases the bus so that an outside source can drive the word to be captured. The disables do not stop any internal operation. Two serial outputs are never released: they always show the low-end stage and the high-end stage.

An active-low clear sets every stage to zero. The build-time parameter `ASYNC_CLEAR` chooses how the clear acts. With the parameter set, the clear acts at once, without the clock. With it cleared, the clear takes effect at the next rising edge and overrides any load or shift at that edge.

Top module: `univ_shift_reg`

## Requirements
- R1: Mode 2'b00 (hold) leaves every stage unchanged at the rising edge.
- R2: Mode 2'b01 (shift up) loads `ser_up_in` into stage 0 and moves stage i-1 into stage i for every i from 1 to WIDTH-1.
- R3: Mode 2'b10 (shift down) loads `ser_dn_in` into stage WIDTH-1 and moves stage i+1 into stage i for every i from 0 to WIDTH-2.
- R4: Mode 2'b11 (load) captures `bus_in` into the stages at the rising edge. Bit i of `bus_in` goes to stage i.
- R5: `bus_oe` is 1 exactly when `out_dis_a` and `out_dis_b` are both 0 and the mode is not 2'b11. When `bus_oe` is 1, `bus_out` equals the stages. When `bus_oe` is 0, `bus_out` is all zeros.
- R6: The disable inputs have no effect on hold, shift or load. The contents built up while the bus is disabled appear on `bus_out` once the bus is enabled again.
- R7: With `ASYNC_CLEAR`=1, a low `clr_n` sets all stages to zero at once, without waiting for a clock edge.
- R8: With `ASYNC_CLEAR`=0, a low `clr_n` has no effect until the next rising edge. At that edge it sets all stages to zero and overrides shift and load.
- R9: `stage_lo` always equals stage 0 and `stage_hi` always equals stage WIDTH-1. Neither depends on the disable inputs.
- R10: The clear value is all zeros. While `clr_n` stays low, no mode changes the stages, so load and shift leave them at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, async or sync per `ASYNC_CLEAR` |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| out_dis_a | input | 1 | Active-high bus disable, first input |
| out_dis_b | input | 1 | Active-high bus disable, second input |
| ser_up_in | input | 1 | Serial input to stage 0 during shift up |
| ser_dn_in | input | 1 | Serial input to stage WIDTH-1 during shift down |
| bus_in | input | WIDTH | Level on the shared pins, captured in load mode |
| bus_out | output | WIDTH | Value driven onto the shared pins |
| bus_oe | output | 1 | Drive enable for the shared pins |
| stage_lo | output | 1 | Always-driven copy of stage 0 |
| stage_hi | output | 1 | Always-driven copy of stage WIDTH-1 |

## Verification
Each mode's result is stored on the rising edge where the mode is applied. It appears on `bus_out`, `stage_lo` and `stage_hi` right after that edge, through a single register. The bench therefore drives inputs on the falling edge and samples 2 ns after the next rising edge. `bus_oe` and the zero gating of `bus_out` are combinational from the current mode and disables, so they are checked against the inputs still applied at the sample point. An asynchronous clear is checked 1 ns after `clr_n` falls, with no edge in between. The synchronous copy is checked at the same instant to show that it still holds its old value, and again after the following edge to show that it has cleared.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DN   = 2'b10,
        MODE_LOAD = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/usr_next.sv
module usr_next
    import usr_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter bit SYNC_CLR  = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  shift_mode_e      mode,
    input  logic             ser_up,
    input  logic             ser_dn,
    input  logic [WIDTH-1:0] par_in,
    input  logic             clr_n,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] up_val;
    logic [WIDTH-1:0] dn_val;

    // Shifted words are built bit by bit so each stage's source is explicit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_lo
            assign up_val[i] = ser_up;
        end else begin : g_up
            assign up_val[i] = cur[i-1];
        end
        if (i == TOP) begin : g_hi
            assign dn_val[i] = ser_dn;
        end else begin : g_dn
            assign dn_val[i] = cur[i+1];
        end
    end

    always_comb begin
        unique case (mode)
            MODE_HOLD: nxt = cur;
            MODE_UP:   nxt = up_val;
            MODE_DN:   nxt = dn_val;
            MODE_LOAD: nxt = par_in;
            default:   nxt = cur;
        endcase
        // In the synchronous variant, clear wins over every mode at the edge.
        if (SYNC_CLR && !clr_n) begin
            nxt = '0;
        end
    end

endmodule

// File: rtl/usr_bus_drive.sv
module usr_bus_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] stages,
    input  logic             dis_a,
    input  logic             dis_b,
    input  logic             load_sel,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             stage_lo,
    output logic             stage_hi
);

    logic drive;

    always_comb begin
        drive    = !(dis_a || dis_b || load_sel);
        bus_oe   = drive;
        bus_out  = drive ? stages : '0;
        stage_lo = stages[0];
        stage_hi = stages[WIDTH-1];
    end

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             out_dis_a,
    input  logic             out_dis_b,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             stage_lo,
    output logic             stage_hi
);

    localparam bit SYNC_CLR = !ASYNC_CLEAR;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } state_t;

    state_t      st_d;
    state_t      st_q;
    shift_mode_e mode_e;

    assign mode_e = shift_mode_e'(mode);

    usr_next #(
        .WIDTH    (WIDTH),
        .SYNC_CLR (SYNC_CLR)
    ) u_next (
        .cur    (st_q.stages),
        .mode   (mode_e),
        .ser_up (ser_up_in),
        .ser_dn (ser_dn_in),
        .par_in (bus_in),
        .clr_n  (clr_n),
        .nxt    (st_d.stages)
    );

    // The parameter picks the flop style: with or without the async clear.
    if (ASYNC_CLEAR) begin : g_async
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
    end else begin : g_sync
        always_ff @(posedge clk) begin
            st_q <= st_d;
        end
    end

    usr_bus_drive #(
        .WIDTH (WIDTH)
    ) u_drive (
        .stages   (st_q.stages),
        .dis_a    (out_dis_a),
        .dis_b    (out_dis_b),
        .load_sel (mode_e == MODE_LOAD),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .stage_lo (stage_lo),
        .stage_hi (stage_hi)
    );

    // ---------------- assertions ----------------
    a_r1_hold_keeps: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b00) |=> (bus_out == $past(bus_out) || !bus_oe)
                                     && stage_lo == $past(stage_lo)
                                     && stage_hi == $past(stage_hi));

    a_r2_shift_up: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b01) |=> stage_lo == $past(ser_up_in)
                                     && stage_hi == $past(st_q.stages[WIDTH-2]));

    a_r3_shift_dn: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b10) |=> stage_hi == $past(ser_dn_in)
                                     && stage_lo == $past(st_q.stages[1]));

    a_r4_load_capture: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b11) |=> st_q.stages == $past(bus_in));

    a_r5_load_releases: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11 || out_dis_a || out_dis_b) |-> (!bus_oe && bus_out == '0));

    if (ASYNC_CLEAR) begin : g_clr_chk
        a_r7_async_zero: assert property (@(posedge clk)
            !clr_n |-> (st_q.stages == '0 && !stage_lo && !stage_hi));
    end else begin : g_clr_chk
        a_r8_sync_zero: assert property (@(posedge clk)
            !clr_n |=> (st_q.stages == '0 && !stage_lo && !stage_hi));
    end

endmodule

// File: tb/tb_univ_shift_reg.sv
module tb_univ_shift_reg;

    localparam int W = 8;

    typedef struct packed {
        logic [1:0]   mode;
        logic         da;
        logic         db;
        logic         sup;
        logic         sdn;
        logic [W-1:0] pin;
        logic [W-1:0] exp_q;
        logic         exp_oe;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0},
        '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1},
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h4B, 1'b1},
        '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h96, 1'b1},
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hCB, 1'b1},
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h65, 1'b0},
        '{2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hCB, 1'b0},
        '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hCB, 1'b1},
        '{2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0},
        '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b1},
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h1E, 1'b1},
        '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b1}
    };

    logic         clk = 1'b0;
    logic         clr_n;
    logic [1:0]   mode;
    logic         dis_a, dis_b, sup, sdn;
    logic [W-1:0] pin;
    logic [W-1:0] a_out, s_out;
    logic         a_oe, s_oe, a_lo, a_hi, s_lo, s_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    univ_shift_reg #(.WIDTH(W), .ASYNC_CLEAR(1'b1)) dut (
        .clk(clk), .clr_n(clr_n), .mode(mode), .out_dis_a(dis_a), .out_dis_b(dis_b),
        .ser_up_in(sup), .ser_dn_in(sdn), .bus_in(pin),
        .bus_out(a_out), .bus_oe(a_oe), .stage_lo(a_lo), .stage_hi(a_hi));

    univ_shift_reg #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) dut_sync (
        .clk(clk), .clr_n(clr_n), .mode(mode), .out_dis_a(dis_a), .out_dis_b(dis_b),
        .ser_up_in(sup), .ser_dn_in(sdn), .bus_in(pin),
        .bus_out(s_out), .bus_oe(s_oe), .stage_lo(s_lo), .stage_hi(s_hi));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        clr_n = 1'b0; mode = 2'b11; dis_a = 1'b0; dis_b = 1'b0;
        sup = 1'b0; sdn = 1'b0; pin = 8'hFF;
        repeat (3) @(posedge clk);
        #2;
        // R10: clear holds zero even in load mode with all-ones on the bus
        chk("R10 async lo/hi under load", {a_lo, a_hi}, 0);
        chk("R8 sync clear overrides load", {s_lo, s_hi}, 0);
        chk("R5 load releases bus", a_oe, 0);
        @(negedge clk); mode = 2'b00;
        #1;
        chk("R10 reset bus zero", a_out, 0);
        chk("R5 hold drives bus", a_oe, 1);
        clr_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string mt;
            @(negedge clk);
            mode = TBL[i].mode; dis_a = TBL[i].da; dis_b = TBL[i].db;
            sup = TBL[i].sup; sdn = TBL[i].sdn; pin = TBL[i].pin;
            edge_sample();
            case (TBL[i].mode)
                2'b00: mt = "R1 hold";
                2'b01: mt = "R2 shift up";
                2'b10: mt = "R3 shift down";
                default: mt = "R4 load";
            endcase
            if (TBL[i].da || TBL[i].db) mt = {mt, " R6 disabled"};
            chk({mt, " R5 oe"}, a_oe, TBL[i].exp_oe);
            chk({mt, " R5 bus"}, a_out, TBL[i].exp_oe ? TBL[i].exp_q : 8'h00);
            chk({mt, " R9 ends"}, {a_hi, a_lo}, {TBL[i].exp_q[W-1], TBL[i].exp_q[0]});
            chk({mt, " sync copy"}, {s_oe, s_out, s_hi, s_lo},
                {a_oe, a_out, TBL[i].exp_q[W-1], TBL[i].exp_q[0]});
        end

        // R7 / R8: clear dropped mid-cycle, contents 3C
        @(negedge clk);
        mode = 2'b00; dis_a = 1'b0; dis_b = 1'b0;
        #1 clr_n = 1'b0;
        #1;
        chk("R7 async clear immediate", a_out, 8'h00);
        chk("R8 sync clear waits for edge", s_out, 8'h3C);
        edge_sample();
        chk("R8 sync clear at edge", s_out, 8'h00);
        @(negedge clk); clr_n = 1'b1;

        // R8 / R10: clear overrides shift after loading all ones
        mode = 2'b11; pin = 8'hFF;
        edge_sample();
        @(negedge clk); mode = 2'b01; sup = 1'b1; clr_n = 1'b0;
        edge_sample();
        chk("R8 sync clear overrides shift", {s_hi, s_lo}, 0);
        chk("R10 async clear over shift", {a_hi, a_lo}, 0);
        @(negedge clk); clr_n = 1'b1; mode = 2'b00; sup = 1'b0;

        // R9 / R6: serial outputs while the bus is fully disabled
        @(negedge clk); dis_a = 1'b1; dis_b = 1'b1; mode = 2'b11; pin = 8'h81;
        edge_sample();
        chk("R9 ends while disabled", {a_hi, a_lo, s_hi, s_lo}, 4'hF);
        chk("R5 both disabled", {a_oe, a_out}, 0);
        @(negedge clk); mode = 2'b01; sup = 1'b0;
        edge_sample();
        chk("R9 ends after shift up", {a_hi, a_lo}, 0);
        @(negedge clk); mode = 2'b00; dis_a = 1'b0; dis_b = 1'b0;
        #1;
        chk("R6 contents kept while disabled", a_out, 8'h02);
        chk("R6 sync copy", s_out, 8'h02);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule